// File: doc/BRIEF.md
# Narrow-Port FIFO Word Packer/Unpacker

This block joins a pair of 32-bit, four-word FIFOs to a local data port that is either 8 or 16 bits wide. In the inbound direction, a wide-side producer pushes whole words. The local side then takes each head word apart, one byte or halfword per read strobe. In the outbound direction, the local side writes bytes or halfwords. These are assembled into a word that enters the outbound FIFO, and a wide-side consumer pops the finished words.

The port width is taken from a select input, but only while reset is held. A live byte-order input decides whether the least or the most significant sub-word moves first. Two clear strobes return the inbound and outbound sub-word pointers to the first position. The clear strobes stand for the moment each channel is disabled. Two active-low request outputs let a simple local DMA controller service the FIFOs without processor polling. Both local strobes are single-cycle, synchronous to `clk`.

Top module: `nport_fifo_bridge`

## Requirements
- R1: `pw_sel_i` is captured only while `rst` is high: 1 selects the 8-bit port (four accesses per word) and 0 selects the 16-bit port (two accesses per word). Changing it after reset has no effect on the access count or lane layout.
- R2: In 8-bit mode with `big_end_i`=0, the word 00C0FFEEh reads out as EE, FF, C0, 00. With `big_end_i`=1 it reads out as 00, C0, FF, EE. Bits 15:8 of `lrdata_o` are zero.
- R3: In 16-bit mode with `big_end_i`=0, the word 00C0FFEEh reads out as FFEE then 00C0. With `big_end_i`=1 it reads out as 00C0 then FFEE.
- R4: Read data appears on `lrdata_o` in the cycle after the `lrd_i` strobe and holds until the next accepted read. The inbound FIFO pops only on the read of the final sub-word position.
- R5: A read while the inbound FIFO is empty leaves `lrdata_o` and the read pointer unchanged.
- R6: Writes place `lwdata_i` (bits 7:0 in 8-bit mode) into lanes in the same order as reads. The assembled word enters the outbound FIFO only when the final sub-word position is written.
- R7: A write while the outbound FIFO is full is ignored and the write pointer does not advance.
- R8: `rd_clr_i` returns the read pointer to the first position. `wr_clr_i` returns the write pointer to the first position and discards the partial word.
- R9: `rd_dreq_n_o` is low exactly while the inbound FIFO holds at least one word. `wr_dreq_n_o` is low exactly while the outbound FIFO has space.
- R10: Each FIFO holds four words. `in_empty_o`, `in_full_o`, `out_empty_o` and `out_full_o` report occupancy, and a push into a full inbound FIFO is dropped.
- R11: After reset, both FIFOs are empty, `lrdata_o` is 0, `rd_dreq_n_o` is high and `wr_dreq_n_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pw_sel_i | input | 1 | Port width select sampled during reset (1 = 8-bit, 0 = 16-bit) |
| big_end_i | input | 1 | Sub-word order (0 = least significant first) |
| rd_clr_i | input | 1 | Clears the inbound sub-word pointer |
| wr_clr_i | input | 1 | Clears the outbound sub-word pointer and partial word |
| lrd_i | input | 1 | Local read strobe |
| lwr_i | input | 1 | Local write strobe |
| lwdata_i | input | 16 | Local write data |
| lrdata_o | output | 16 | Local read data, registered |
| in_push_i | input | 1 | Wide-side push into the inbound FIFO |
| in_data_i | input | 32 | Word pushed into the inbound FIFO |
| in_full_o | output | 1 | Inbound FIFO full |
| in_empty_o | output | 1 | Inbound FIFO empty |
| out_pop_i | input | 1 | Wide-side pop from the outbound FIFO |
| out_data_o | output | 32 | Head word of the outbound FIFO |
| out_empty_o | output | 1 | Outbound FIFO empty |
| out_full_o | output | 1 | Outbound FIFO full |
| rd_dreq_n_o | output | 1 | Active-low request: inbound data available |
| wr_dreq_n_o | output | 1 | Active-low request: outbound space available |

## Verification
The bench aims at several boundaries.

- **Last lane of each word.** A design that pops or commits one access early would lose the top sub-word. Such a design would also show the FIFO emptying after three byte reads.
- **Write into a full outbound FIFO.** If the write pointer moved anyway, the next word would be assembled with its bytes rotated by one lane.
- **Clear strobes.** A pointer that survives a clear would return the second byte instead of the first.
- **Reads from an empty FIFO.** A design that does not hold here would change `lrdata_o` on those reads.
- **Port width changed after reset.** A design that followed the live input would switch from two to four accesses per word.

A random phase then mixes pushes, pops, strobes and byte-order changes against a queue-based model.

// File: rtl/nport_pkg.sv
package nport_pkg;

    localparam int WORD_W  = 32;
    localparam int PORT_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int HALF_W  = 16;
    localparam int LANE_W  = $clog2(WORD_W / BYTE_W);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [PORT_W-1:0] port_t;
    typedef logic [LANE_W-1:0] lane_t;

    typedef enum logic {
        PW_HALF = 1'b0,
        PW_BYTE = 1'b1
    } port_width_e;

    // Highest sub-word position for the selected port width
    function automatic lane_t last_lane(port_width_e pw);
        return (pw == PW_BYTE) ? lane_t'(WORD_W / BYTE_W - 1)
                               : lane_t'(WORD_W / HALF_W - 1);
    endfunction

    // Access position to physical lane, honouring byte order
    function automatic lane_t map_lane(lane_t ptr, logic big, port_width_e pw);
        lane_t top;
        top = last_lane(pw);
        return big ? lane_t'(top - ptr) : ptr;
    endfunction

    function automatic port_t pick(word_t w, lane_t lane, port_width_e pw);
        port_t r;
        if (pw == PW_BYTE)
            r = port_t'(w[{lane, 3'b000} +: BYTE_W]);
        else
            r = w[{lane[0], 4'b0000} +: HALF_W];
        return r;
    endfunction

    function automatic word_t place(word_t w, lane_t lane, port_width_e pw, port_t d);
        word_t r;
        r = w;
        if (pw == PW_BYTE)
            r[{lane, 3'b000} +: BYTE_W] = d[BYTE_W-1:0];
        else
            r[{lane[0], 4'b0000} +: HALF_W] = d;
        return r;
    endfunction

endpackage

// File: rtl/nport_fifo.sv
module nport_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          push_ok, pop_ok;

    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == CW'(DEPTH));
    assign push_ok = push_i && !full_o;
    assign pop_ok  = pop_i && !empty_o;
    assign head_o  = mem[rp_q];

    function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : AW'(p + 1'b1);
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp_q] <= data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) wp_q <= nxt(wp_q);
            if (pop_ok)  rp_q <= nxt(rp_q);
            case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/nport_unpack.sv
module nport_unpack
    import nport_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  port_width_e pw_i,
    input  logic        big_i,
    input  logic        rd_i,
    input  logic        clr_i,
    input  word_t       head_i,
    input  logic        empty_i,
    output logic        pop_o,
    output port_t       rdata_o
);
    lane_t ptr_q;
    port_t rdata_q;
    logic  take;

    assign take    = rd_i && !empty_i && !clr_i;
    assign pop_o   = take && (ptr_q == last_lane(pw_i));
    assign rdata_o = rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            rdata_q <= '0;
        end else if (clr_i) begin
            ptr_q <= '0;
        end else if (take) begin
            rdata_q <= pick(head_i, map_lane(ptr_q, big_i, pw_i), pw_i);
            ptr_q   <= pop_o ? '0 : lane_t'(ptr_q + 1'b1);
        end
    end
endmodule

// File: rtl/nport_pack.sv
module nport_pack
    import nport_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  port_width_e pw_i,
    input  logic        big_i,
    input  logic        wr_i,
    input  logic        clr_i,
    input  port_t       wdata_i,
    input  logic        full_i,
    output logic        push_o,
    output word_t       word_o,
    output lane_t       ptr_o
);
    lane_t ptr_q;
    word_t asm_q;
    word_t merged;
    logic  accept;

    assign accept = wr_i && !full_i && !clr_i;
    assign merged = place(asm_q, map_lane(ptr_q, big_i, pw_i), pw_i, wdata_i);
    assign push_o = accept && (ptr_q == last_lane(pw_i));
    assign word_o = merged;
    assign ptr_o  = ptr_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            ptr_q <= '0;
            asm_q <= '0;
        end else if (accept) begin
            asm_q <= push_o ? '0 : merged;
            ptr_q <= push_o ? '0 : lane_t'(ptr_q + 1'b1);
        end
    end
endmodule

// File: rtl/nport_fifo_bridge.sv
module nport_fifo_bridge
    import nport_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pw_sel_i,
    input  logic        big_end_i,
    input  logic        rd_clr_i,
    input  logic        wr_clr_i,
    input  logic        lrd_i,
    input  logic        lwr_i,
    input  logic [15:0] lwdata_i,
    output logic [15:0] lrdata_o,
    input  logic        in_push_i,
    input  logic [31:0] in_data_i,
    output logic        in_full_o,
    output logic        in_empty_o,
    input  logic        out_pop_i,
    output logic [31:0] out_data_o,
    output logic        out_empty_o,
    output logic        out_full_o,
    output logic        rd_dreq_n_o,
    output logic        wr_dreq_n_o
);
    port_width_e mode_q;
    word_t       in_head;
    logic        in_pop;
    logic        out_push;
    word_t       out_word;
    lane_t       wr_ptr;

    // Port width is only taken while reset is held
    always_ff @(posedge clk) begin
        if (rst) mode_q <= port_width_e'(pw_sel_i);
    end

    nport_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_in_fifo (
        .clk     (clk),
        .rst     (rst),
        .push_i  (in_push_i),
        .data_i  (in_data_i),
        .pop_i   (in_pop),
        .head_o  (in_head),
        .empty_o (in_empty_o),
        .full_o  (in_full_o)
    );

    nport_unpack u_unpack (
        .clk     (clk),
        .rst     (rst),
        .pw_i    (mode_q),
        .big_i   (big_end_i),
        .rd_i    (lrd_i),
        .clr_i   (rd_clr_i),
        .head_i  (in_head),
        .empty_i (in_empty_o),
        .pop_o   (in_pop),
        .rdata_o (lrdata_o)
    );

    nport_pack u_pack (
        .clk     (clk),
        .rst     (rst),
        .pw_i    (mode_q),
        .big_i   (big_end_i),
        .wr_i    (lwr_i),
        .clr_i   (wr_clr_i),
        .wdata_i (lwdata_i),
        .full_i  (out_full_o),
        .push_o  (out_push),
        .word_o  (out_word),
        .ptr_o   (wr_ptr)
    );

    nport_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_out_fifo (
        .clk     (clk),
        .rst     (rst),
        .push_i  (out_push),
        .data_i  (out_word),
        .pop_i   (out_pop_i),
        .head_o  (out_data_o),
        .empty_o (out_empty_o),
        .full_o  (out_full_o)
    );

    assign rd_dreq_n_o = in_empty_o;
    assign wr_dreq_n_o = out_full_o;
endmodule

// File: rtl/nport_bridge_chk.sv
module nport_bridge_chk
    import nport_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        lrd_i,
    input logic        lwr_i,
    input logic        wr_clr_i,
    input logic        in_push_i,
    input logic        in_full_o,
    input logic        in_empty_o,
    input logic        out_pop_i,
    input logic        out_empty_o,
    input logic        out_full_o,
    input logic [15:0] lrdata_o,
    input logic        rd_dreq_n_o,
    input logic        wr_dreq_n_o,
    input port_width_e mode_q,
    input lane_t       wr_ptr
);
    lane_t final_pos;
    assign final_pos = (mode_q == PW_BYTE) ? lane_t'(3) : lane_t'(1);

    a_r1_mode_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(mode_q));

    a_r5_empty_read_holds: assert property (@(posedge clk) disable iff (rst)
        (lrd_i && in_empty_o) |=> $stable(lrdata_o));

    a_r6_no_early_commit: assert property (@(posedge clk) disable iff (rst)
        (lwr_i && !wr_clr_i && out_empty_o && !out_full_o && wr_ptr != final_pos)
        |=> out_empty_o);

    a_r7_full_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (lwr_i && out_full_o && !out_pop_i) |=> (out_full_o && $stable(wr_ptr)));

    a_r9_rd_request: assert property (@(posedge clk) disable iff (rst)
        (in_push_i && !in_full_o) |=> !rd_dreq_n_o);

    a_r9_wr_request: assert property (@(posedge clk) disable iff (rst)
        (out_pop_i && !out_empty_o) |=> !wr_dreq_n_o);

    a_r10_drop_on_full: assert property (@(posedge clk) disable iff (rst)
        (in_push_i && in_full_o && !lrd_i) |=> in_full_o);
endmodule

bind nport_fifo_bridge nport_bridge_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .lrd_i       (lrd_i),
    .lwr_i       (lwr_i),
    .wr_clr_i    (wr_clr_i),
    .in_push_i   (in_push_i),
    .in_full_o   (in_full_o),
    .in_empty_o  (in_empty_o),
    .out_pop_i   (out_pop_i),
    .out_empty_o (out_empty_o),
    .out_full_o  (out_full_o),
    .lrdata_o    (lrdata_o),
    .rd_dreq_n_o (rd_dreq_n_o),
    .wr_dreq_n_o (wr_dreq_n_o),
    .mode_q      (mode_q),
    .wr_ptr      (wr_ptr)
);

// File: tb/nport_fifo_bridge_bench.sv
module nport_fifo_bridge_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pw_sel = 1'b1, big = 1'b0, rd_clr = 1'b0, wr_clr = 1'b0;
    logic        lrd = 1'b0, lwr = 1'b0, in_push = 1'b0, out_pop = 1'b0;
    logic [15:0] lwdata = '0;
    logic [31:0] in_data = '0;
    logic [15:0] lrdata;
    logic [31:0] out_data;
    logic        in_full, in_empty, out_empty, out_full, rd_dreq_n, wr_dreq_n;

    always #10 clk = ~clk;

    nport_fifo_bridge u_nport_fifo_bridge (
        .clk(clk), .rst(rst), .pw_sel_i(pw_sel), .big_end_i(big),
        .rd_clr_i(rd_clr), .wr_clr_i(wr_clr), .lrd_i(lrd), .lwr_i(lwr),
        .lwdata_i(lwdata), .lrdata_o(lrdata), .in_push_i(in_push),
        .in_data_i(in_data), .in_full_o(in_full), .in_empty_o(in_empty),
        .out_pop_i(out_pop), .out_data_o(out_data), .out_empty_o(out_empty),
        .out_full_o(out_full), .rd_dreq_n_o(rd_dreq_n), .wr_dreq_n_o(wr_dreq_n)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] inq[$];
    logic [31:0] outq[$];
    int          rpos = 0, wpos = 0;
    logic [31:0] asmw = '0;
    logic [15:0] rexp = '0;
    bit          mbyte = 1'b1;
    bit          live = 1'b0;

    function automatic logic [31:0] lane_mask(bit byte_m);
        return byte_m ? 32'h0000_00FF : 32'h0000_FFFF;
    endfunction

    function automatic int lane_shift(int k, bit byte_m, bit be);
        int n;
        n = byte_m ? 4 : 2;
        return (be ? (n - 1 - k) : k) * (byte_m ? 8 : 16);
    endfunction

    always @(posedge clk) begin
        int n, isz, osz, sh;
        if (rst) begin
            mbyte = pw_sel;
            inq.delete();
            outq.delete();
            rpos = 0; wpos = 0; asmw = '0; rexp = '0;
            live = 1'b1;
        end else begin
            n   = mbyte ? 4 : 2;
            isz = inq.size();
            osz = outq.size();
            if (rd_clr) rpos = 0;
            else if (lrd && isz > 0) begin
                sh   = lane_shift(rpos, mbyte, big);
                rexp = 16'((inq[0] >> sh) & lane_mask(mbyte));
                if (rpos == n - 1) begin
                    void'(inq.pop_front());
                    rpos = 0;
                end else rpos++;
            end
            if (in_push && isz < 4) inq.push_back(in_data);
            if (out_pop && osz > 0) void'(outq.pop_front());
            if (wr_clr) begin
                wpos = 0; asmw = '0;
            end else if (lwr && osz < 4) begin
                sh   = lane_shift(wpos, mbyte, big);
                asmw = (asmw & ~(lane_mask(mbyte) << sh)) |
                       ((32'(lwdata) & lane_mask(mbyte)) << sh);
                if (wpos == n - 1) begin
                    outq.push_back(asmw);
                    wpos = 0; asmw = '0;
                end else wpos++;
            end
        end
    end

    // lockstep comparison every cycle, away from the active edge
    always @(negedge clk) begin
        if (live) begin
            chk(lrdata === rexp, "R4", 32'(lrdata), 32'(rexp));
            chk(in_empty === (inq.size() == 0), "R10", 32'(in_empty), 32'(inq.size() == 0));
            chk(in_full === (inq.size() == 4), "R10", 32'(in_full), 32'(inq.size() == 4));
            chk(out_empty === (outq.size() == 0), "R10", 32'(out_empty), 32'(outq.size() == 0));
            chk(out_full === (outq.size() == 4), "R10", 32'(out_full), 32'(outq.size() == 4));
            chk(rd_dreq_n === (inq.size() == 0), "R9", 32'(rd_dreq_n), 32'(inq.size() == 0));
            chk(wr_dreq_n === (outq.size() == 4), "R9", 32'(wr_dreq_n), 32'(outq.size() == 4));
            if (outq.size() > 0)
                chk(out_data === outq[0], "R6", out_data, outq[0]);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(negedge clk);
    endtask

    task automatic push_in(input logic [31:0] w);
        in_push = 1'b1; in_data = w; step(); in_push = 1'b0;
    endtask

    task automatic rd(output logic [15:0] v);
        lrd = 1'b1; step(); lrd = 1'b0; v = lrdata;
    endtask

    task automatic wr(input logic [15:0] d);
        lwr = 1'b1; lwdata = d; step(); lwr = 1'b0;
    endtask

    task automatic pop_out();
        out_pop = 1'b1; step(); out_pop = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  exp_le [4];
        logic [7:0]  exp_be [4];
        exp_le = '{8'hEE, 8'hFF, 8'hC0, 8'h00};
        exp_be = '{8'h00, 8'hC0, 8'hFF, 8'hEE};

        // byte-wide port
        pw_sel = 1'b1; rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        step();
        chk(lrdata == 16'h0, "R11", 32'(lrdata), 32'h0);
        chk(in_empty && out_empty, "R11", {30'b0, in_empty, out_empty}, 32'h3);
        chk(rd_dreq_n == 1'b1, "R11", 32'(rd_dreq_n), 32'h1);
        chk(wr_dreq_n == 1'b0, "R11", 32'(wr_dreq_n), 32'h0);

        push_in(32'h00C0_FFEE);
        chk(rd_dreq_n == 1'b0, "R9", 32'(rd_dreq_n), 32'h0);
        for (int k = 0; k < 4; k++) begin
            rd(v);
            chk(v == 16'(exp_le[k]), "R2", 32'(v), 32'(exp_le[k]));
            if (k == 2) chk(!in_empty, "R4", 32'(in_empty), 32'h0);
        end
        chk(in_empty, "R4", 32'(in_empty), 32'h1);

        big = 1'b1;
        push_in(32'h00C0_FFEE);
        for (int k = 0; k < 4; k++) begin
            rd(v);
            chk(v == 16'(exp_be[k]), "R2", 32'(v), 32'(exp_be[k]));
        end
        rd(v);
        chk(v == 16'h00EE, "R5", 32'(v), 32'h00EE);

        big = 1'b0;
        push_in(32'h1122_3344);
        rd(v);
        rd_clr = 1'b1; step(); rd_clr = 1'b0;
        rd(v);
        chk(v == 16'h0044, "R8", 32'(v), 32'h44);
        rd(v); rd(v); rd(v);
        chk(v == 16'h0011, "R8", 32'(v), 32'h11);
        chk(in_empty, "R8", 32'(in_empty), 32'h1);

        wr(16'h00EE); wr(16'h00FF); wr(16'h00C0);
        chk(out_empty, "R6", 32'(out_empty), 32'h1);
        wr(16'h0000);
        chk(out_data == 32'h00C0_FFEE, "R6", out_data, 32'h00C0_FFEE);
        pop_out();
        big = 1'b1;
        wr(16'h0000); wr(16'h00C0); wr(16'h00FF); wr(16'h00EE);
        chk(out_data == 32'h00C0_FFEE, "R6", out_data, 32'h00C0_FFEE);
        pop_out();
        big = 1'b0;

        wr(16'h00AA);
        wr_clr = 1'b1; step(); wr_clr = 1'b0;
        wr(16'h0044); wr(16'h0033); wr(16'h0022); wr(16'h0011);
        chk(out_data == 32'h1122_3344, "R8", out_data, 32'h1122_3344);
        pop_out();

        for (int w = 0; w < 4; w++)
            for (int b = 0; b < 4; b++) wr(16'(w * 16 + b));
        chk(out_full && wr_dreq_n, "R7", {30'b0, out_full, wr_dreq_n}, 32'h3);
        wr(16'h0055);
        chk(out_full, "R7", 32'(out_full), 32'h1);
        pop_out();
        wr(16'h0001); wr(16'h0002); wr(16'h0003); wr(16'h0004);
        pop_out(); pop_out(); pop_out();
        chk(out_data == 32'h0403_0201, "R7", out_data, 32'h0403_0201);
        pop_out();

        for (int w = 0; w < 5; w++) push_in(32'hA000_0000 + 32'(w));
        chk(in_full, "R10", 32'(in_full), 32'h1);
        for (int k = 0; k < 16; k++) rd(v);
        chk(in_empty, "R10", 32'(in_empty), 32'h1);

        // halfword port; width input moved after reset must not matter
        pw_sel = 1'b0; rst = 1'b1;
        repeat (2) step();
        rst = 1'b0;
        step();
        pw_sel = 1'b1;
        push_in(32'h00C0_FFEE);
        rd(v);
        chk(v == 16'hFFEE, "R3", 32'(v), 32'hFFEE);
        rd(v);
        chk(v == 16'h00C0, "R3", 32'(v), 32'h00C0);
        chk(in_empty, "R1", 32'(in_empty), 32'h1);
        big = 1'b1;
        push_in(32'h00C0_FFEE);
        rd(v);
        chk(v == 16'h00C0, "R3", 32'(v), 32'h00C0);
        rd(v);
        chk(v == 16'hFFEE, "R3", 32'(v), 32'hFFEE);
        big = 1'b0;
        wr(16'hFFEE); wr(16'h00C0);
        chk(out_data == 32'h00C0_FFEE, "R6", out_data, 32'h00C0_FFEE);
        pop_out();

        // random mix against the model, both widths
        for (int pass = 0; pass < 2; pass++) begin
            pw_sel = 1'(pass); rst = 1'b1;
            repeat (2) step();
            rst = 1'b0;
            for (int c = 0; c < 3000; c++) begin
                in_push = ($urandom_range(0, 2) == 0);
                in_data = $urandom;
                lrd     = ($urandom_range(0, 1) == 0);
                lwr     = ($urandom_range(0, 1) == 0);
                lwdata  = 16'($urandom);
                out_pop = ($urandom_range(0, 4) == 0);
                rd_clr  = ($urandom_range(0, 60) == 0);
                wr_clr  = ($urandom_range(0, 60) == 0);
                if ($urandom_range(0, 200) == 0) big = ~big;
                step();
            end
            {in_push, lrd, lwr, out_pop, rd_clr, wr_clr} = '0;
            step();
        end

        finish_run();
    end
endmodule